// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block derives the clock for a contact card from a fast reference. It divides by one, two, four or eight under a two-bit ratio code. The block runs on a clock at twice the reference-crystal rate, so one crystal half-period equals `XTAL_HALF` block cycles (one by default). Every output edge then comes from a register, including the divide-by-one case. The output is therefore free of combinational glitches and can be checked cycle by cycle.

A small state machine drives the output. Its states are PARK (held low, not running), LOW and HIGH (the two phases of a running clock) and SWAP (a stretched low phase that separates two ratios). Its transitions are:
- start: PARK to LOW.
- rise: LOW to HIGH.
- fall: HIGH to LOW.
- retune: HIGH or LOW to SWAP, taken when a phase ends with a ratio change pending.
- resume: SWAP to HIGH, where the new ratio is loaded.
- stop: to PARK. From HIGH it is taken only after the phase completes.

The session sequencer gates the clock with an enable and a force-low input. It uses them to start the clock at a chosen moment and to park it low for deactivation. A pulse is never cut short, whatever these controls do.

Top module: `card_clk_div`

## Requirements
- R1: After reset, `card_clk` is low and the block is in PARK.
- R2: Ratio codes on `div_sel` give these steady half-periods, counted in block cycles with `XTAL_HALF`=1: 2'b00 gives 8, 2'b01 gives 4, 2'b11 gives 2, and 2'b10 gives 1. These are /8, /4, /2 and /1 of the crystal.
- R3: `div_sel` is registered once. When a new code is seen at the end of a HIGH phase, the output then stays low for exactly 16 cycles (8 crystal periods). After that it runs at the new ratio, starting with a full-width high phase.
- R4: A code change never alters the phase in progress. The high phase during which the code changes keeps the old width, provided the change arrives at least one cycle before that phase ends.
- R5: Gate is `clk_en` high and `park_low` low. When the gate opens from PARK, the first rising edge of `card_clk` appears exactly 2 + H cycles later, where H is the half-period of the selected code. A rise is always preceded by the gate being open two cycles earlier.
- R6: If the gate closes during a high phase, that phase still completes at full width. The output then stays low.
- R7: While the gate is closed and the output is low, the output stays low.
- R8: Every high phase lasts exactly XTAL_HALF times 1, 2, 4 or 8 cycles. No runt pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the crystal rate |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 2 | Ratio code (see R2); change one bit at a time |
| clk_en | input | 1 | Sequencer enable for the card clock |
| park_low | input | 1 | Sequencer force-low; overrides `clk_en` |
| card_clk | output | 1 | Divided card clock, registered |

## Verification
A corrupted phase counter or ratio register shows up at `card_clk` within one phase. Within at most 16 cycles, a high pulse has a width outside the allowed set, or a low gap differs from the old half-period or the 16-cycle swap gap. A wrong state transition shows up as a pulse that is cut short or appears too early. It can also show up as a rise while the gate is closed, or as an output that stays low after a start. Each of these is visible at the next edge that state should have produced. The bench measures every pulse and gap across each ratio change, start and stop. The checker watches high widths and rises relative to the gate on every cycle.

// File: rtl/scd_pkg.sv
package scd_pkg;

    typedef enum logic [1:0] {
        ST_PARK = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_SWAP = 2'd3
    } scd_state_e;

endpackage

// File: rtl/scd_ratio_dec.sv
module scd_ratio_dec #(
    parameter int XTAL_HALF = 1,
    parameter int CNT_W     = 5
) (
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] half_len
);
    logic [1:0] shift;

    // non-binary code: 00 slowest, 10 fastest
    always_comb begin
        unique case (code)
            2'b00:   shift = 2'd3;
            2'b01:   shift = 2'd2;
            2'b11:   shift = 2'd1;
            default: shift = 2'd0;
        endcase
    end

    assign half_len = CNT_W'(XTAL_HALF) << shift;
endmodule

// File: rtl/scd_phase_cnt.sv
module scd_phase_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign done = (cnt == len - 1'b1);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div #(
    parameter int XTAL_HALF    = 1,
    parameter int SWAP_PERIODS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_sel,
    input  logic       clk_en,
    input  logic       park_low,
    output logic       card_clk
);
    import scd_pkg::*;

    localparam int SWAP_LEN = 2 * XTAL_HALF * SWAP_PERIODS;
    localparam int CNT_W    = $clog2(SWAP_LEN) + 1;

    scd_state_e       state, nxt;
    logic [1:0]       sel_q, ratio_act;
    logic             run_q, take_sel, done, clk_q;
    logic [CNT_W-1:0] half_len, phase_len;

    // input registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 2'b00;
            run_q <= 1'b0;
        end else begin
            sel_q <= div_sel;
            run_q <= clk_en & ~park_low;
        end
    end

    scd_ratio_dec #(.XTAL_HALF(XTAL_HALF), .CNT_W(CNT_W)) u_dec (
        .code     (ratio_act),
        .half_len (half_len)
    );

    assign phase_len = (state == ST_SWAP) ? CNT_W'(SWAP_LEN) : half_len;

    scd_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (nxt != state),
        .len     (phase_len),
        .done    (done)
    );

    // next-state logic
    always_comb begin
        nxt      = state;
        take_sel = 1'b0;
        unique case (state)
            ST_PARK: if (run_q) begin
                nxt      = ST_LOW;
                take_sel = 1'b1;
            end
            ST_LOW: begin
                if (!run_q)    nxt = ST_PARK;
                else if (done) nxt = (sel_q != ratio_act) ? ST_SWAP : ST_HIGH;
            end
            ST_HIGH: if (done) begin
                if (!run_q)                  nxt = ST_PARK;
                else if (sel_q != ratio_act) nxt = ST_SWAP;
                else                         nxt = ST_LOW;
            end
            ST_SWAP: begin
                if (!run_q) nxt = ST_PARK;
                else if (done) begin
                    nxt      = ST_HIGH;
                    take_sel = 1'b1;
                end
            end
            default: nxt = ST_PARK;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_PARK;
        else     state <= nxt;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_act <= 2'b00;
            clk_q     <= 1'b0;
        end else begin
            if (take_sel) ratio_act <= sel_q;
            clk_q <= (nxt == ST_HIGH);
        end
    end

    assign card_clk = clk_q;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
    parameter int XTAL_HALF = 1
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] div_sel,
    input logic       clk_en,
    input logic       park_low,
    input logic       card_clk
);
    logic       gate;
    logic       rst_d;
    logic [7:0] hi_len;

    assign gate = clk_en & ~park_low;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)                      hi_len <= '0;
        else if (!card_clk)           hi_len <= '0;
        else if (hi_len != 8'hFF)     hi_len <= hi_len + 1'b1;
    end

    // R1: output low once reset has been applied
    always_ff @(posedge clk) begin
        if (rst_d && !rst)
            a_r1_low_after_reset: assert (!card_clk);
    end

    // R8: each high phase has one of the allowed widths
    a_r8_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(card_clk) |-> (hi_len == 8'(XTAL_HALF) || hi_len == 8'(2*XTAL_HALF) ||
                             hi_len == 8'(4*XTAL_HALF) || hi_len == 8'(8*XTAL_HALF)));

    // R8: no high phase runs past the slowest width
    a_r8_high_max: assert property (@(posedge clk) disable iff (rst)
        card_clk |-> (hi_len < 8'(8*XTAL_HALF)));

    // R5: a rise needs the gate open two cycles earlier
    a_r5_rise_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk) |-> $past(gate, 2));

    // R7: closed gate keeps a low output low
    a_r7_hold_low: assert property (@(posedge clk) disable iff (rst)
        (!card_clk && !gate && !$past(gate)) |=> !card_clk);
endmodule

bind card_clk_div card_clk_div_chk #(.XTAL_HALF(XTAL_HALF)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_sel  (div_sel),
    .clk_en   (clk_en),
    .park_low (park_low),
    .card_clk (card_clk)
);

// File: tb/sim_card_clk_div.sv
module sim_card_clk_div;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] div_sel;
    logic       clk_en, park_low;
    logic       card_clk;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    card_clk_div u0 (
        .clk      (clk),
        .rst      (rst),
        .div_sel  (div_sel),
        .clk_en   (clk_en),
        .park_low (park_low),
        .card_clk (card_clk)
    );

    // {code, half-period}
    localparam logic [1:0] TAB_SEL [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
    localparam int         TAB_HP  [4] = '{8, 4, 2, 1};
    localparam int         CAP = 100;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (card_clk == lvl && n < CAP) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise();
        int g = 0;
        while (card_clk == 1'b1 && g < CAP) begin g++; @(negedge clk); end
        while (card_clk == 1'b0 && g < 2*CAP) begin g++; @(negedge clk); end
    endtask

    task automatic first_rise(output int at);
        at = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (card_clk && at == 0) at = i;
            if (at != 0) break;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int h1, l1, h2, l2, at, prev_hp;
        logic [1:0] cur;
        rst = 1'b1; div_sel = 2'b00; clk_en = 1'b0; park_low = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: low after reset, gate closed keeps it low
        chk("R1", "reset level", card_clk, 0);
        repeat (20) @(negedge clk);
        chk("R7", "idle level", card_clk, 0);

        // R5: start latency with code 00
        clk_en = 1'b1;
        first_rise(at);
        chk("R5", "start latency /8", at, 2 + 8);

        // table walk over ratio codes
        cur = 2'b00; prev_hp = 8;
        for (int i = 0; i < 4; i++) begin
            wait_rise();
            div_sel = TAB_SEL[i];
            run_len(1'b1, h1);
            run_len(1'b0, l1);
            run_len(1'b1, h2);
            run_len(1'b0, l2);
            chk("R4", "high in progress", h1, prev_hp);
            chk("R3", "gap at change", l1, (TAB_SEL[i] != cur) ? 16 : prev_hp);
            chk("R8", "first new high", h2, TAB_HP[i]);
            chk("R2", "steady low", l2, TAB_HP[i]);
            cur = TAB_SEL[i]; prev_hp = TAB_HP[i];
        end

        // move to code 01 and settle
        div_sel = 2'b01;
        repeat (3) wait_rise();

        // R6: force-low in a high phase
        wait_rise();
        park_low = 1'b1;
        run_len(1'b1, h1);
        run_len(1'b0, l1);
        chk("R6", "last high width", h1, 4);
        chk("R6", "parked low", l1, CAP);

        // R5: restart with code 01
        park_low = 1'b0;
        first_rise(at);
        chk("R5", "restart latency /4", at, 2 + 4);

        // R7: enable dropped during low phase
        run_len(1'b1, h1);
        chk("R8", "restart high", h1, 4);
        clk_en = 1'b0;
        run_len(1'b0, l1);
        chk("R7", "stays low", l1, CAP);

        // R1: reset while running
        clk_en = 1'b1;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "reset mid-run", card_clk, 0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule